// File: doc/BRIEF.md
# Asynchronous-to-Synchronous Transmit Rate Converter

This block sits between an asynchronous character source and a modulator that needs a steady bit stream. In asynchronous mode it oversamples the incoming serial line, recovers start-framed characters, holds them in a small elastic buffer and sends them again on a fixed output bit grid. If the source runs slightly fast, the buffer fills. The converter then makes up the difference by cutting the stop bit of an outgoing character short, but only while another character is already waiting.

Two bypass paths need no character framing. In synchronous mode the line is sampled once per output bit period and sent on unchanged. In frequency-shift mode the line goes straight to the output. Both time bases come in as clock enables: one tick per input oversample and one tick per sixteenth of an output bit.

Top module: `a2s_rate_conv`

## Requirements
- R1: After reset, `dout` is 1 and `frame_err` is 0.
- R2: In asynchronous mode (`mode` = 2'b00), each received character goes out as a 0 start bit, then 8 data bits with the least significant bit first, then a 1 stop bit. Every output bit lasts 16 `tx_tick`s, and characters leave in the order they arrived.
- R3: A character begins only when a high-to-low change on `din` is still low 8 `rx_tick`s later, at the middle of the start bit. A shorter low pulse sends nothing.
- R4: When no character is waiting, the output holds 1. Output bits stay on a 16-tick grid. If a character's stop bit begins while the buffer is empty, that stop bit is full width, so the time from one start edge to the next is a multiple of 16 ticks and at least 160.
- R5: If at least one character is waiting when a stop bit begins, the stop bit is shortened. It lasts 15 ticks when `ext_ovs` = 0 and 14 ticks (7/8 of a bit) when `ext_ovs` = 1. This gives start-to-start spacings of 159 and 158.
- R6: A buffer of two characters absorbs a source whose characters are spaced 159 input ticks apart. A long burst is delivered complete and in order in both overspeed settings.
- R7: If a stop bit is sampled low, `frame_err` goes to 1 and stays there until reset. The character is still sent on.
- R8: In synchronous mode (`mode` = 2'b01), `dout` takes the value of `din` at each 16-tick bit boundary.
- R9: In frequency-shift mode (`mode` = 2'b10), `dout` follows `din` directly, with no register in the path.
- R10: Mode code 2'b11 acts the same as 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | Input oversample enable (16 per input bit) |
| tx_tick | input | 1 | Output time-base enable (16 per nominal output bit) |
| mode | input | 2 | 00 asynchronous, 01 synchronous, 10/11 frequency-shift bypass |
| ext_ovs | input | 1 | Selects the 7/8-width shortened stop bit |
| din | input | 1 | Serial input line |
| dout | output | 1 | Re-timed serial output |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The receiver can push a finished character into the buffer in the same cycle that the serializer reaches a stop-bit boundary and reads the buffer level to choose the stop width. When the buffer is full, a push can also land in the same cycle as a pop. Back-to-back bursts with characters spaced 159 ticks apart make the push time slide past the serializer's boundary by one tick per character, so the two events are bound to coincide at some point in the burst. The bench decodes the output line on its own. It then checks that every byte arrives in order, none lost or repeated, and that every start-to-start spacing is either a legal full-width multiple of 16 or the single shortened value allowed for the selected overspeed setting.

// File: rtl/a2s_pkg.sv
package a2s_pkg;

    localparam int unsigned OSR_DEF   = 16;
    localparam int unsigned DATA_DEF  = 8;
    localparam int unsigned DEPTH_DEF = 2;

    typedef enum logic [1:0] {
        XM_ASYNC = 2'b00,
        XM_SYNC  = 2'b01,
        XM_FSK   = 2'b10,
        XM_FSK2  = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // Shortened stop length in output ticks: 7/8 of a bit when extended, one tick less otherwise.
    function automatic int unsigned short_stop_ticks(input logic ext, input int unsigned osr);
        return ext ? (osr * 7) / 8 : osr - 1;
    endfunction

    function automatic logic is_bypass(input xfer_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/a2s_rx_sampler.sv
module a2s_rx_sampler
    import a2s_pkg::*;
#(
    parameter int unsigned OSR    = OSR_DEF,
    parameter int unsigned DATA_W = DATA_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              din,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              frame_err
);
    localparam int unsigned CW  = $clog2(OSR);
    localparam int unsigned BW  = $clog2(DATA_W);
    localparam int unsigned MID = OSR / 2 - 1;

    rx_state_e         state_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              prev_q;
    logic              push_q;
    logic              ferr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            prev_q  <= 1'b1;
            push_q  <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            push_q <= 1'b0;
            if (!en) begin
                state_q <= RX_IDLE;
                prev_q  <= 1'b1;
            end else if (tick) begin
                prev_q <= din;
                unique case (state_q)
                    RX_IDLE: begin
                        if (prev_q && !din) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt_q == CW'(MID)) begin
                            cnt_q   <= '0;
                            bit_q   <= '0;
                            state_q <= din ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == CW'(OSR - 1)) begin
                            cnt_q <= '0;
                            sh_q  <= {din, sh_q[DATA_W-1:1]};
                            if (bit_q == BW'(DATA_W - 1)) state_q <= RX_STOP;
                            else                          bit_q   <= bit_q + BW'(1);
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    RX_STOP: begin
                        if (cnt_q == CW'(OSR - 1)) begin
                            cnt_q   <= '0;
                            push_q  <= 1'b1;
                            state_q <= RX_IDLE;
                            if (!din) ferr_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign push      = push_q;
    assign push_data = sh_q;
    assign frame_err = ferr_q;

    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (rst) ferr_q |=> ferr_q); // R7
    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst) push_q |=> !push_q); // R2

endmodule

// File: rtl/a2s_char_fifo.sv
module a2s_char_fifo
    import a2s_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              not_empty,
    output logic              half_full
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned NW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][DATA_W-1:0] mem_q;
    logic [PW-1:0]                wptr_q, rptr_q;
    logic [NW-1:0]                cnt_q;
    logic                         do_pop, do_push;

    always_comb begin
        do_pop  = pop && (cnt_q != '0);
        do_push = push && ((cnt_q != NW'(DEPTH)) || do_pop);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
            if (do_pop)  rptr_q <= (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
            cnt_q <= cnt_q + NW'(do_push) - NW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                if (do_push && (wptr_q == PW'(i))) mem_q[i] <= wdata;
            end
        end
    end

    assign rdata     = mem_q[rptr_q];
    assign not_empty = (cnt_q != '0);
    assign half_full = (cnt_q >= NW'(DEPTH / 2));

    AST_FIFO_BOUND:    assert property (@(posedge clk) disable iff (rst) cnt_q <= NW'(DEPTH)); // R6
    AST_POP_HAS_DATA:  assert property (@(posedge clk) disable iff (rst) pop |-> cnt_q != '0); // R6

endmodule

// File: rtl/a2s_tx_serializer.sv
module a2s_tx_serializer
    import a2s_pkg::*;
#(
    parameter int unsigned OSR    = OSR_DEF,
    parameter int unsigned DATA_W = DATA_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  xfer_mode_e        mode,
    input  logic              ext_ovs,
    input  logic              din,
    input  logic              have_char,
    input  logic              backlog,
    input  logic [DATA_W-1:0] char_in,
    output logic              pop,
    output logic              dout
);
    localparam int unsigned FRAME_W  = DATA_W + 2;
    localparam int unsigned STOP_IDX = DATA_W + 1;
    localparam int unsigned IW       = $clog2(FRAME_W);
    localparam int unsigned LW       = $clog2(OSR + 1);

    logic [LW-1:0]      cnt_q, blen_q;
    logic [IW-1:0]      idx_q;
    logic [FRAME_W-1:0] frame_q;
    logic               in_char_q;
    logic               dout_q;
    logic               boundary, mid_char;

    always_comb begin
        boundary = tick && (cnt_q == blen_q - LW'(1));
        mid_char = in_char_q && (idx_q != IW'(STOP_IDX));
        pop      = boundary && (mode == XM_ASYNC) && !mid_char && have_char;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            blen_q    <= LW'(OSR);
            idx_q     <= '0;
            frame_q   <= '1;
            in_char_q <= 1'b0;
            dout_q    <= 1'b1;
        end else if (tick) begin
            cnt_q <= boundary ? '0 : cnt_q + LW'(1);
            if (boundary) begin
                blen_q <= LW'(OSR);
                if (mode == XM_ASYNC) begin
                    if (mid_char) begin
                        idx_q  <= idx_q + IW'(1);
                        dout_q <= frame_q[idx_q + IW'(1)];
                        if ((idx_q + IW'(1) == IW'(STOP_IDX)) && backlog)
                            blen_q <= LW'(short_stop_ticks(ext_ovs, OSR));
                    end else if (have_char) begin
                        frame_q   <= {1'b1, char_in, 1'b0};
                        idx_q     <= '0;
                        in_char_q <= 1'b1;
                        dout_q    <= 1'b0;
                    end else begin
                        in_char_q <= 1'b0;
                        dout_q    <= 1'b1;
                    end
                end else if (mode == XM_SYNC) begin
                    in_char_q <= 1'b0;
                    dout_q    <= din;
                end else begin
                    in_char_q <= 1'b0;
                    dout_q    <= 1'b1;
                end
            end
        end
    end

    assign dout = dout_q;

    AST_SHORT_ONLY_STOP: assert property (@(posedge clk) disable iff (rst)
        (blen_q != LW'(OSR)) |-> (in_char_q && idx_q == IW'(STOP_IDX))); // R5
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (blen_q == LW'(OSR)) || (blen_q == LW'(OSR - 1)) || (blen_q == LW'((OSR * 7) / 8))); // R5
    AST_START_FROM_BUFFER: assert property (@(posedge clk) disable iff (rst)
        (pop) |=> (!dout_q && in_char_q && idx_q == '0)); // R2

endmodule

// File: rtl/a2s_rate_conv.sv
module a2s_rate_conv
    import a2s_pkg::*;
#(
    parameter int unsigned OSR    = OSR_DEF,
    parameter int unsigned DATA_W = DATA_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_tick,
    input  logic       tx_tick,
    input  logic [1:0] mode,
    input  logic       ext_ovs,
    input  logic       din,
    output logic       dout,
    output logic       frame_err
);
    xfer_mode_e        mode_e;
    logic              is_async;
    logic              rx_push, fifo_pop, fifo_ne, fifo_half, ser_dout;
    logic [DATA_W-1:0] rx_data, fifo_rdata;

    assign mode_e   = xfer_mode_e'(mode);
    assign is_async = (mode_e == XM_ASYNC);

    a2s_rx_sampler #(.OSR(OSR), .DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .en        (is_async),
        .tick      (rx_tick),
        .din       (din),
        .push      (rx_push),
        .push_data (rx_data),
        .frame_err (frame_err)
    );

    a2s_char_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (!is_async),
        .push      (rx_push),
        .wdata     (rx_data),
        .pop       (fifo_pop),
        .rdata     (fifo_rdata),
        .not_empty (fifo_ne),
        .half_full (fifo_half)
    );

    a2s_tx_serializer #(.OSR(OSR), .DATA_W(DATA_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .tick      (tx_tick),
        .mode      (mode_e),
        .ext_ovs   (ext_ovs),
        .din       (din),
        .have_char (fifo_ne),
        .backlog   (fifo_half),
        .char_in   (fifo_rdata),
        .pop       (fifo_pop),
        .dout      (ser_dout)
    );

    assign dout = is_bypass(mode_e) ? din : ser_dout;

endmodule

// File: tb/test_a2s_rate_conv.sv
module test_a2s_rate_conv;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_tick = 1'b1;
    logic       tx_tick = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       ext_ovs = 1'b0;
    logic       din = 1'b1;
    logic       dout, frame_err;

    a2s_rate_conv i_a2s_rate_conv (
        .clk(clk), .rst(rst), .rx_tick(rx_tick), .tx_tick(tx_tick),
        .mode(mode), .ext_ovs(ext_ovs), .din(din), .dout(dout), .frame_err(frame_err)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output decoder: independent of the design, works from the line only.
    int         tcnt = 0, st = 0, last_st = -1, off = 0, gn = 0, pn = 0;
    bit         in_ch = 1'b0, dec_en = 1'b0;
    logic [7:0] sh = '0;
    logic [7:0] got [0:63];
    int         per [0:63];
    logic [7:0] sent [0:63];

    always @(negedge clk) begin
        tcnt++;
        if (dec_en) begin
            if (!in_ch && dout == 1'b0) begin
                in_ch = 1'b1;
                st = tcnt;
                if (last_st >= 0 && pn < 64) begin
                    per[pn] = st - last_st;
                    pn++;
                end
                last_st = st;
            end else if (in_ch) begin
                off = tcnt - st;
                if (off >= 24 && off <= 136 && ((off - 8) % 16) == 0) sh = {dout, sh[7:1]};
                if (off == 152) begin
                    if (gn < 64) got[gn] = sh;
                    gn++;
                    in_ch = 1'b0;
                end
            end
        end
    end

    task automatic clear_dec();
        gn = 0; pn = 0; last_st = -1; in_ch = 1'b0;
    endtask

    task automatic send_char(input logic [7:0] b, input int stop_ticks, input logic stop_val);
        din = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            din = b[i];
            repeat (16) @(negedge clk);
        end
        din = stop_val;
        repeat (stop_ticks) @(negedge clk);
        din = 1'b1;
    endtask

    function automatic bit legal_period(input int p, input int short_p);
        return (p == short_p) || (p >= 160 && (p % 16) == 0);
    endfunction

    task automatic burst(input bit ext, input string req, input int short_p);
        int n_short = 0;
        ext_ovs = ext;
        clear_dec();
        for (int i = 0; i < 20; i++) begin
            sent[i] = $urandom;
            send_char(sent[i], 15, 1'b1);
        end
        repeat (700) @(negedge clk);
        chk(gn == 20, "R6 burst count", gn, 20);
        for (int i = 0; i < 20; i++) chk(got[i] == sent[i], "R6 burst byte", got[i], sent[i]);
        for (int i = 0; i < pn; i++) begin
            if (per[i] == short_p) n_short++;
            chk(legal_period(per[i], short_p), req, per[i], short_p);
        end
        chk(n_short >= 1, req, n_short, 1);
    endtask

    initial begin
        logic b;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        chk(dout == 1'b1, "R1 dout idle", dout, 1);
        chk(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(dout == 1'b1, "R4 idle mark", dout, 1);

        // Gapped characters: R2 format and order, R4 full stops only
        dec_en = 1'b1;
        clear_dec();
        sent[0] = 8'h00; sent[1] = 8'hFF; sent[2] = 8'hA5;
        for (int i = 3; i < 6; i++) sent[i] = $urandom;
        for (int i = 0; i < 6; i++) begin
            send_char(sent[i], 16, 1'b1);
            repeat (40) @(negedge clk);
        end
        repeat (400) @(negedge clk);
        chk(gn == 6, "R2 char count", gn, 6);
        for (int i = 0; i < 6; i++) chk(got[i] == sent[i], "R2 byte", got[i], sent[i]);
        for (int i = 0; i < pn; i++)
            chk(per[i] >= 160 && (per[i] % 16) == 0, "R4 full stop period", per[i], 160);

        // R3: short low glitch starts nothing
        clear_dec();
        din = 1'b0;
        repeat (3) @(negedge clk);
        din = 1'b1;
        repeat (300) @(negedge clk);
        chk(gn == 0 && dout == 1'b1, "R3 glitch ignored", gn, 0);

        // R5/R6: overspeed bursts
        burst(1'b0, "R5 normal short stop", 159);
        burst(1'b1, "R5 extended short stop", 158);

        // R7: framing error
        ext_ovs = 1'b0;
        clear_dec();
        chk(frame_err == 1'b0, "R7 before error", frame_err, 0);
        send_char(8'h3C, 16, 1'b0);
        repeat (60) @(negedge clk);
        repeat (250) @(negedge clk);
        chk(frame_err == 1'b1, "R7 flag set", frame_err, 1);
        chk(gn == 1 && got[0] == 8'h3C, "R7 char forwarded", got[0], 8'h3C);
        send_char(8'h5A, 16, 1'b1);
        repeat (300) @(negedge clk);
        chk(frame_err == 1'b1, "R7 sticky", frame_err, 1);
        chk(gn == 2 && got[1] == 8'h5A, "R7 next char", got[1], 8'h5A);

        // R8: synchronous sampling at bit boundaries
        dec_en = 1'b0;
        mode = 2'b01;
        repeat (32) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            b = (i < 2) ? i[0] : 1'($urandom);
            din = b;
            repeat (32) @(negedge clk);
            chk(dout == b, "R8 sync bit", dout, b);
        end

        // R9/R10: direct pass-through
        mode = 2'b10;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            din = 1'($urandom);
            #1;
            chk(dout == din, "R9 fsk pass", dout, din);
        end
        mode = 2'b11;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            din = ~din;
            #1;
            chk(dout == din, "R10 alt code pass", dout, din);
        end
        din = 1'b1;
        mode = 2'b00;
        repeat (40) @(negedge clk);
        chk(dout == 1'b1, "R4 idle after mode return", dout, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule